// File: doc/BRIEF.md
# Audio-Sharing Bulk Serial Transmitter

This block takes bytes from an upstream byte source and sends them one bit at a time, most significant bit first, on an open-drain data line. A separate framing output marks each run of bytes. Both outputs follow an external bulk bit clock of 1.544 or 2.048 MHz. The block oversamples that bit clock, together with the frame-sync and FIFO-full inputs, in its own system clock domain. New output values appear shortly after each rising edge of the bit clock, so a receiver that samples on the falling edge sees settled data.

The same wires also carry an audio codec stream. When audio is marked present, each left-channel frame sync gives the line to the codec for a fixed number of bit clocks: 16 in mono, 32 in stereo. During that time the data line is released to high-Z. A byte that is cut off by a frame sync is kept and sent again, whole, once the line is free. A FIFO-full input from the receiver stops transmission at the next byte boundary. Sending picks up again at the MSB of the next byte once the input clears. A mode input can release both outputs to high-Z at any time.

Top module: `bulk_tx`

## Requirements
- R1: After synchronous reset, the data and framing output enables (`dat_oe_o`, `blk_en_oe_o`) are 0 and no byte is taken from the source.
- R2: While `cfg_io_en_i` is 0, both output enables are 0 from the next clock on, and no byte is taken from the source.
- R3: Each byte is sent MSB first, one bit per bit-clock period. Data and framing outputs change only after a rising bit-clock edge and hold steady across the following falling edge.
- R4: The framing output is 1 from the MSB of the first byte of a run to the LSB of its last byte, with no gap between back-to-back bytes. It returns to 0 when the source is empty. The data line is owned (`dat_oe_o`=1) exactly while the driven framing level is 1.
- R5: With audio absent (`cfg_audio_i`=0), sending starts without any frame sync, and a frame sync has no effect on the stream.
- R6: When `fifo_full_i` is seen as 1 at a byte boundary, the framing output goes to 0, the data line is released and no byte is taken. Sending resumes at the MSB of the next byte after the input returns to 0. A byte already under way completes.
- R7: With audio present in mono, the line is released for 16 bit periods. These begin with the period that starts at the rising edge where the frame sync is first seen high. The next byte's MSB goes out in the 17th period.
- R8: With audio present in stereo (`cfg_stereo_i`=1), the same release lasts 32 bit periods.
- R9: With audio present, nothing is sent after reset until the first frame sync and its release period have passed. After that, sending continues until the next frame sync.
- R10: A frame sync that arrives in the middle of a byte abandons that byte on the line. After the release period the byte is sent again from its MSB, and it is not taken from the source a second time.
- R11: The data pad pulls low only when `dat_oe_o`=1 and `dat_o`=0. In every other case the line floats to the external pull-up level.
- R12: Every byte offered by the source is taken exactly once, with a one-cycle `src_pop_o` pulse that only follows a cycle where `src_valid_i` was 1. Bytes go out in the order they were offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset (power-on or soft reset) |
| bit_clk_i | input | 1 | Bulk bit clock from the receiver |
| frame_sync_i | input | 1 | Left-channel audio frame sync, high for one bit period |
| fifo_full_i | input | 1 | Receiver FIFO full; 1 pauses sending |
| cfg_io_en_i | input | 1 | 1 lets the block drive its outputs |
| cfg_audio_i | input | 1 | 1 when an audio stream shares the line |
| cfg_stereo_i | input | 1 | 1 for stereo audio (32-clock release), 0 for mono (16) |
| src_valid_i | input | 1 | Byte source holds a byte |
| src_data_i | input | BYTE_W | Byte presented by the source |
| src_pop_o | output | 1 | One-cycle pulse taking the presented byte |
| dat_o | output | 1 | Serial data value |
| dat_oe_o | output | 1 | Data pad enable; pad pulls low when 1 and `dat_o`=0 |
| blk_en_o | output | 1 | Framing level, 1 while a byte run is on the line |
| blk_en_oe_o | output | 1 | Framing pad enable; 0 leaves the pin high-Z |

## Verification
A wrong bit index or a lost held-byte flag shows up within one byte time: the scoreboard receives a corrupted or out-of-order byte at the next eighth bit, or a byte is skipped. A wrong release counter shows as a frame-sync-to-first-MSB distance other than 16 or 32 bit periods, and this is measured at the very first byte after each sync. A pause or ownership error appears at once as the data enable disagreeing with the framing level, or as a byte taken from the source while the FIFO-full input is high.

// File: rtl/bulk_tx_pkg.sv
`timescale 1ns/1ps
package bulk_tx_pkg;
  // Width of the synchronised input bundle and its lane positions.
  localparam int SYNC_LANES = 3;
  localparam int LANE_BCLK  = 0;
  localparam int LANE_FS    = 1;
  localparam int LANE_FULL  = 2;

  // Release length, in bit periods, for a given audio mode.
  function automatic int gap_len(input logic stereo, input int mono_n, input int stereo_n);
    return stereo ? stereo_n : mono_n;
  endfunction
endpackage

// File: rtl/bulk_tx_sync.sv
`timescale 1ns/1ps
module bulk_tx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bulk_tx_gap.sv
`timescale 1ns/1ps
module bulk_tx_gap
  import bulk_tx_pkg::*;
#(
  parameter int MONO_GAP   = 16,
  parameter int STEREO_GAP = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic fs_i,
  input  logic audio_i,
  input  logic stereo_i,
  output logic fs_hit_o,
  output logic open_o,
  output logic busy_o
);
  localparam int GAP_MAX = (STEREO_GAP > MONO_GAP) ? STEREO_GAP : MONO_GAP;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic             busy_q;
  logic             armed_q;
  logic             fs_last_q;
  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] reload;

  assign reload   = GAP_W'(gap_len(stereo_i, MONO_GAP, STEREO_GAP) - 1);
  assign fs_hit_o = tick_i & fs_i & ~fs_last_q & audio_i;
  assign open_o   = ~audio_i | (~fs_hit_o & (busy_q ? (cnt_q == '0) : armed_q));
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      armed_q   <= 1'b0;
      fs_last_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (tick_i) fs_last_q <= fs_i;
      if (!audio_i) begin
        busy_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (tick_i) begin
        if (fs_hit_o) begin
          busy_q  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= reload;
        end else if (busy_q) begin
          if (cnt_q == '0) begin
            busy_q  <= 1'b0;
            armed_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bulk_tx_core.sv
`timescale 1ns/1ps
module bulk_tx_core #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              fs_hit_i,
  input  logic              gap_open_i,
  input  logic              full_i,
  input  logic              io_en_i,
  input  logic              src_valid_i,
  input  logic [BYTE_W-1:0] src_data_i,
  output logic              src_pop_o,
  output logic              dat_o,
  output logic              en_o
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              have_q;
  logic              en_q;
  logic              dat_q;
  logic              pop_q;

  logic              last_bit;
  logic              have_eff;
  logic              can_go;
  logic [BYTE_W-1:0] next_byte;

  assign last_bit  = en_q & (idx_q == '0);
  assign have_eff  = have_q & ~last_bit;
  assign can_go    = gap_open_i & ~full_i & io_en_i & (have_eff | src_valid_i);
  assign next_byte = have_eff ? shreg_q : src_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      idx_q   <= '0;
      have_q  <= 1'b0;
      en_q    <= 1'b0;
      dat_q   <= 1'b1;
      pop_q   <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (tick_i) begin
        if (fs_hit_i) begin
          en_q   <= 1'b0;
          dat_q  <= 1'b1;
          idx_q  <= IDX_TOP;
          have_q <= have_eff;
        end else if (en_q && idx_q != '0) begin
          idx_q <= idx_q - 1'b1;
          dat_q <= shreg_q[idx_q - 1'b1];
        end else if (can_go) begin
          if (!have_eff) begin
            shreg_q <= src_data_i;
            pop_q   <= 1'b1;
          end
          have_q <= 1'b1;
          en_q   <= 1'b1;
          idx_q  <= IDX_TOP;
          dat_q  <= next_byte[BYTE_W-1];
        end else begin
          en_q   <= 1'b0;
          dat_q  <= 1'b1;
          have_q <= have_eff;
        end
      end
    end
  end

  assign src_pop_o = pop_q;
  assign dat_o     = dat_q;
  assign en_o      = en_q;
endmodule

// File: rtl/bulk_tx.sv
`timescale 1ns/1ps
module bulk_tx
  import bulk_tx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MONO_GAP    = 16,
  parameter int STEREO_GAP  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_clk_i,
  input  logic              frame_sync_i,
  input  logic              fifo_full_i,
  input  logic              cfg_io_en_i,
  input  logic              cfg_audio_i,
  input  logic              cfg_stereo_i,
  input  logic              src_valid_i,
  input  logic [BYTE_W-1:0] src_data_i,
  output logic              src_pop_o,
  output logic              dat_o,
  output logic              dat_oe_o,
  output logic              blk_en_o,
  output logic              blk_en_oe_o
);
  logic [SYNC_LANES-1:0] raw_in;
  logic [SYNC_LANES-1:0] sy;
  logic bclk_last_q;
  logic tick;
  logic fs_hit;
  logic gap_open;
  logic gap_busy;
  logic en_q;
  logic dat_q;
  logic full_s;

  always_comb begin
    raw_in            = '0;
    raw_in[LANE_BCLK] = bit_clk_i;
    raw_in[LANE_FS]   = frame_sync_i;
    raw_in[LANE_FULL] = fifo_full_i;
  end

  bulk_tx_sync #(.WIDTH(SYNC_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (sy)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_last_q <= 1'b0;
    else     bclk_last_q <= sy[LANE_BCLK];
  end

  assign tick   = sy[LANE_BCLK] & ~bclk_last_q;
  assign full_s = sy[LANE_FULL];

  bulk_tx_gap #(.MONO_GAP(MONO_GAP), .STEREO_GAP(STEREO_GAP)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .fs_i     (sy[LANE_FS]),
    .audio_i  (cfg_audio_i),
    .stereo_i (cfg_stereo_i),
    .fs_hit_o (fs_hit),
    .open_o   (gap_open),
    .busy_o   (gap_busy)
  );

  bulk_tx_core #(.BYTE_W(BYTE_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .fs_hit_i    (fs_hit),
    .gap_open_i  (gap_open),
    .full_i      (full_s),
    .io_en_i     (cfg_io_en_i),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_pop_o   (src_pop_o),
    .dat_o       (dat_q),
    .en_o        (en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_o       <= 1'b1;
      dat_oe_o    <= 1'b0;
      blk_en_o    <= 1'b0;
      blk_en_oe_o <= 1'b0;
    end else begin
      dat_o       <= dat_q;
      dat_oe_o    <= cfg_io_en_i & en_q;
      blk_en_o    <= en_q;
      blk_en_oe_o <= cfg_io_en_i;
    end
  end
endmodule

// File: rtl/bulk_tx_chk.sv
`timescale 1ns/1ps
module bulk_tx_chk (
  input logic clk,
  input logic rst,
  input logic cfg_io_en_i,
  input logic src_valid_i,
  input logic src_pop_o,
  input logic dat_oe_o,
  input logic blk_en_o,
  input logic blk_en_oe_o,
  input logic tick,
  input logic full_s,
  input logic gap_busy,
  input logic en_q,
  input logic dat_q
);
  // R2: a disabled pad pair is released on the next clock
  a_r2_io_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg_io_en_i |=> (!dat_oe_o && !blk_en_oe_o));

  // R4: data line is owned only inside a framed run
  a_r4_data_in_frame: assert property (@(posedge clk) disable iff (rst)
    dat_oe_o |-> blk_en_o);

  // R6: no byte is taken at a boundary that sees the FIFO full
  a_r6_no_pop_when_full: assert property (@(posedge clk) disable iff (rst)
    (tick && full_s) |=> !src_pop_o);

  // R7: nothing is framed while the audio release is running
  a_r7_gap_silent: assert property (@(posedge clk) disable iff (rst)
    gap_busy |-> !en_q);

  // R3: line values move only on a rising bit-clock edge
  a_r3_move_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(en_q) && $stable(dat_q)));

  // R12: a pop follows a cycle in which the source offered a byte
  a_r12_pop_needs_valid: assert property (@(posedge clk) disable iff (rst)
    src_pop_o |-> $past(src_valid_i));
endmodule

bind bulk_tx bulk_tx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_io_en_i (cfg_io_en_i),
  .src_valid_i (src_valid_i),
  .src_pop_o   (src_pop_o),
  .dat_oe_o    (dat_oe_o),
  .blk_en_o    (blk_en_o),
  .blk_en_oe_o (blk_en_oe_o),
  .tick        (tick),
  .full_s      (full_s),
  .gap_busy    (gap_busy),
  .en_q        (en_q),
  .dat_q       (dat_q)
);

// File: tb/tb_bulk_tx.sv
`timescale 1ns/1ps
module tb_bulk_tx;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0;
  logic fs = 1'b0;
  logic full = 1'b0;
  logic cfg_io = 1'b0;
  logic cfg_audio = 1'b0;
  logic cfg_stereo = 1'b0;
  logic src_valid = 1'b0;
  logic [BW-1:0] src_data = '0;
  logic src_pop, dat_o, dat_oe, blk_en, blk_en_oe;
  wire  dat_pin = (dat_oe && !dat_o) ? 1'b0 : 1'b1;

  logic [BW-1:0] src_q [$];
  logic [BW-1:0] exp_q [$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  initial forever begin
    repeat (6) @(negedge clk);
    bclk = ~bclk;
  end

  bulk_tx dut (
    .clk(clk), .rst(rst), .bit_clk_i(bclk), .frame_sync_i(fs), .fifo_full_i(full),
    .cfg_io_en_i(cfg_io), .cfg_audio_i(cfg_audio), .cfg_stereo_i(cfg_stereo),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_pop_o(src_pop),
    .dat_o(dat_o), .dat_oe_o(dat_oe), .blk_en_o(blk_en), .blk_en_oe_o(blk_en_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Source model: pops on the pulse, then refreshes the offered byte.
  always @(negedge clk) begin
    if (src_pop && src_q.size() != 0) void'(src_q.pop_front());
    src_valid = (src_q.size() != 0);
    src_data  = (src_q.size() != 0) ? src_q[0] : '0;
  end

  task automatic push(input logic [BW-1:0] b);
    src_q.push_back(b);
    exp_q.push_back(b);
  endtask

  task automatic wait_bits(input int n);
    repeat (n) @(negedge bclk);
    #5;
  endtask

  task automatic pulse_fs();
    @(negedge bclk); #5 fs = 1'b1;
    @(negedge bclk); #5 fs = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 3000) begin
      @(negedge bclk);
      guard++;
    end
    wait_bits(4);
    check(exp_q.size() == 0, "R12 all bytes received", exp_q.size(), 0);
    check(src_q.size() == 0, "R12 all bytes taken", src_q.size(), 0);
    check((blk_en_oe & blk_en) == 1'b0, "R4 frame low when empty", blk_en, 0);
    check(dat_oe == 1'b0, "R4 data released when empty", dat_oe, 0);
    check(dat_pin == 1'b1, "R11 released pin floats high", dat_pin, 1);
  endtask

  // Monitor / scoreboard, sampling at the falling bit-clock edge.
  logic [BW-1:0] acc = '0;
  int nb = 0;
  bit gap_on = 0;
  int gap_cnt = 0;
  always @(negedge bclk) begin
    if (!rst) begin
      automatic logic en_lvl = blk_en_oe & blk_en;
      automatic logic pin_s = dat_pin;
      check(dat_oe == en_lvl, "R4 data owned iff framed", dat_oe, en_lvl);
      if (cfg_audio && fs) begin
        gap_on = 1;
        gap_cnt = 0;
      end
      if (gap_on) begin
        if (!en_lvl) gap_cnt++;
        else begin
          if (cfg_stereo) check(gap_cnt == 32, "R8 stereo release length", gap_cnt, 32);
          else            check(gap_cnt == 16, "R7 mono release length", gap_cnt, 16);
          gap_on = 0;
        end
      end
      if (en_lvl) begin
        acc = {acc[BW-2:0], pin_s};
        nb++;
        if (nb == BW) begin
          if (exp_q.size() == 0) check(1'b0, "R12 unexpected byte", acc, -1);
          else begin
            automatic logic [BW-1:0] e = exp_q.pop_front();
            check(acc == e, "R3 byte MSB first", acc, e);
          end
          nb = 0;
        end
      end else begin
        nb = 0;
      end
      #60;
      check(((blk_en_oe & blk_en) == en_lvl) && (dat_pin == pin_s),
            "R3 steady across falling edge", dat_pin, pin_s);
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(dat_oe == 1'b0, "R1 data enable after reset", dat_oe, 0);
    check(blk_en_oe == 1'b0, "R1 frame enable after reset", blk_en_oe, 0);

    // R2: outputs disabled, nothing consumed
    push(8'hA5); push(8'h3C); push(8'hFF); push(8'h00);
    wait_bits(30);
    check(dat_oe == 1'b0, "R2 data enable while disabled", dat_oe, 0);
    check(blk_en_oe == 1'b0, "R2 frame enable while disabled", blk_en_oe, 0);
    check(src_q.size() == 4, "R2 no byte taken while disabled", src_q.size(), 4);

    // R5/R3/R4: audio absent, immediate start, back-to-back bytes
    cfg_io = 1'b1;
    wait_bits(3);
    check((blk_en_oe & blk_en) == 1'b1, "R5 starts without frame sync", blk_en, 1);
    drain();

    // R5: frame sync ignored without audio
    push(8'h81); push(8'h7E); push(8'h5A); push(8'hC3);
    wait_bits(10);
    pulse_fs();
    for (int i = 0; i < 4; i++) begin
      check((blk_en_oe & blk_en) == 1'b1, "R5 frame sync ignored", blk_en, 1);
      wait_bits(1);
    end
    drain();

    // R6: FIFO full pause at a byte boundary
    push(8'h12); push(8'h34); push(8'h56); push(8'h78); push(8'h9A); push(8'hBC);
    wait_bits(12);
    full = 1'b1;
    wait_bits(16);
    check((blk_en_oe & blk_en) == 1'b0, "R6 frame low while full", blk_en, 0);
    check(dat_oe == 1'b0, "R6 data released while full", dat_oe, 0);
    begin
      automatic int held = src_q.size();
      wait_bits(8);
      check(src_q.size() == held, "R6 no byte taken while full", src_q.size(), held);
    end
    full = 1'b0;
    drain();

    // R9/R7/R10: mono audio
    cfg_audio = 1'b1;
    for (int i = 0; i < 8; i++) push(8'(8'h21 * (i + 1)));
    wait_bits(20);
    check((blk_en_oe & blk_en) == 1'b0, "R9 silent before first sync", blk_en, 0);
    check(src_q.size() == 8, "R9 nothing taken before first sync", src_q.size(), 8);
    pulse_fs();
    wait_bits(27);
    check((blk_en_oe & blk_en) == 1'b1, "R9 sending after release", blk_en, 1);
    pulse_fs();
    wait_bits(2);
    check((blk_en_oe & blk_en) == 1'b0, "R10 byte abandoned at sync", blk_en, 0);
    drain();

    // R8: stereo audio
    cfg_stereo = 1'b1;
    push(8'hE7); push(8'h18); push(8'h6B);
    pulse_fs();
    drain();

    cfg_audio = 1'b0;
    cfg_io = 1'b0;
    wait_bits(2);
    check(blk_en_oe == 1'b0, "R2 frame enable released on disable", blk_en_oe, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule